// File: doc/BRIEF.md
# Multi-Cycle Scan Test Sequencer

This block sequences a mux-based scan chain through one complete test pattern. It raises scan enable and the functional-clock enable to shift an initialization vector into the chain. It then issues an activation phase of m clocked cycles, where m is programmable. In that phase scan enable follows one of three launch schemes. Last, it shifts the captured response out. The first run after reset therefore takes a load, an activation and an unload.

The vector for the next pattern enters the chain on the same cycles as the unload. For this reason, every later run starts directly with its activation phase and skips a separate load.

The tester supplies vector bits on `pat_i` whenever `pat_req_o` is high. It collects response bits from `resp_o` whenever `resp_valid_o` is high. The chain and the logic under test sit outside. Every chain cell updates on a clock edge only while `clk_en_o` is high. It takes its scan neighbour when `scan_en_o` is high and functional data when `scan_en_o` is low.

Top module: `mcyc_scan_seq`

## Requirements
- R1: After reset and whenever no run is in progress, `scan_en_o`, `clk_en_o`, `pat_req_o`, `resp_valid_o` and `done_o` are all 0.
- R2: The first run after reset begins with CHAIN_LEN clocked cycles that have scan enable high, with `chain_si_o` equal to `pat_i` and `pat_req_o` high.
- R3: Mode code 0 (capture launch) issues m clocked cycles with scan enable low. Mode code 3 is treated as code 0.
- R4: Mode code 1 (shift launch) issues one clocked shift cycle with scan enable high, then m-1 clocked cycles with scan enable low.
- R5: Mode code 2 (shift then capture) issues m-1 clocked shift cycles with scan enable high, then one clocked cycle with scan enable low.
- R6: An m input of 0 behaves exactly like m = 1, so the activation phase is one cycle long.
- R7: The unload lasts CHAIN_LEN clocked cycles with scan enable high. During it, `resp_valid_o` is high, `resp_o` follows `chain_so_i` and `chain_si_o` follows `pat_i`. After it the chain holds the next vector, and the next run has no load phase.
- R8: `done_o` is high for exactly one cycle. That cycle follows the last unload cycle and lies 2·CHAIN_LEN+m+1 cycles after the start edge (CHAIN_LEN+m+1 when no load is needed). All enables are low in the cycle after it.
- R9: Mode and m are captured when a start is accepted. A start pulse that arrives during a run, including in the done cycle, has no effect.
- R10: Scan enable is high only in cycles where the functional-clock enable is high. The clock enable becomes active only in the cycle after an accepted start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run a pattern |
| mode_i | input | 2 | Launch scheme: 0 capture, 1 shift, 2 shift-then-capture, 3 as 0 |
| m_i | input | MW | Activation cycle count (0 treated as 1) |
| pat_i | input | 1 | Next vector bit from the tester |
| chain_si_o | output | 1 | Serial input to the scan chain |
| chain_so_i | input | 1 | Serial output of the scan chain |
| pat_req_o | output | 1 | A vector bit is consumed this cycle |
| resp_o | output | 1 | Response bit for the tester |
| resp_valid_o | output | 1 | `resp_o` carries a response bit |
| scan_en_o | output | 1 | Scan enable for every chain cell |
| clk_en_o | output | 1 | Functional-clock enable for the chain and logic |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Completion of one run and the request for the next can meet in the same cycle. The bench provokes this by holding a start pulse exactly in the cycle where `done_o` is seen, and then checks that the enables stay low for the following idle cycles. In selected runs it also pulses start, with a different mode and count, during the load or activation phase. In those runs the activation trace and the captured response must still match what the originally requested scheme predicts.

// File: rtl/mcyc_scan_pkg.sv
package mcyc_scan_pkg;

    typedef enum logic [1:0] {
        MODE_CAP = 2'd0,
        MODE_SHF = 2'd1,
        MODE_STC = 2'd2
    } launch_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_ACT    = 3'd2,
        PH_UNLOAD = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

endpackage

// File: rtl/mcyc_scan_count.sv
module mcyc_scan_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    logic [W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == limit_i);
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = last_o ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/mcyc_scan_ctrl.sv
module mcyc_scan_ctrl
    import mcyc_scan_pkg::*;
#(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [MW-1:0] m_i,
    input  logic          sh_last_i,
    input  logic          act_last_i,
    output phase_e        phase_o,
    output launch_e       mode_o,
    output logic [MW-1:0] act_lim_o,
    output logic          sh_en_o,
    output logic          act_en_o,
    output logic          clr_o
);

    typedef struct packed {
        phase_e        phase;
        launch_e       mode;
        logic [MW-1:0] act_lim;
        logic          full;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{phase: PH_IDLE, mode: MODE_CAP, act_lim: '0, full: 1'b0};

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        sh_en_o  = 1'b0;
        act_en_o = 1'b0;
        clr_o    = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                clr_o = 1'b1;
                if (start_i) begin
                    ctl_d.mode    = (mode_i == 2'd3) ? MODE_CAP : launch_e'(mode_i);
                    ctl_d.act_lim = (m_i == '0) ? '0 : m_i - MW'(1);
                    ctl_d.phase   = ctl_q.full ? PH_ACT : PH_LOAD;
                end
            end
            PH_LOAD: begin
                sh_en_o = 1'b1;
                if (sh_last_i) begin
                    ctl_d.phase = PH_ACT;
                end
            end
            PH_ACT: begin
                act_en_o = 1'b1;
                if (act_last_i) begin
                    ctl_d.phase = PH_UNLOAD;
                end
            end
            PH_UNLOAD: begin
                sh_en_o = 1'b1;
                if (sh_last_i) begin
                    ctl_d.phase = PH_DONE;
                    ctl_d.full  = 1'b1;
                end
            end
            PH_DONE: begin
                ctl_d.phase = PH_IDLE;
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTRL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_o   = ctl_q.phase;
    assign mode_o    = ctl_q.mode;
    assign act_lim_o = ctl_q.act_lim;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase != PH_IDLE) |=>
            ((ctl_q.phase == PH_IDLE) || ($stable(ctl_q.mode) && $stable(ctl_q.act_lim))));

    // R2
    load_only_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_LOAD) |-> !ctl_q.full);

endmodule

// File: rtl/mcyc_scan_path.sv
module mcyc_scan_path
    import mcyc_scan_pkg::*;
#(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_i,
    input  launch_e       mode_i,
    input  logic [MW-1:0] act_cnt_i,
    input  logic [MW-1:0] act_lim_i,
    input  logic          pat_i,
    input  logic          chain_so_i,
    output logic          chain_si_o,
    output logic          pat_req_o,
    output logic          resp_o,
    output logic          resp_valid_o,
    output logic          scan_en_o,
    output logic          clk_en_o,
    output logic          done_o
);

    logic act_se;
    logic shifting;

    always_comb begin
        unique case (mode_i)
            MODE_SHF: act_se = (act_cnt_i == '0);
            MODE_STC: act_se = (act_cnt_i != act_lim_i);
            default:  act_se = 1'b0;
        endcase
    end

    always_comb begin
        clk_en_o  = 1'b0;
        scan_en_o = 1'b0;
        unique case (phase_i)
            PH_LOAD, PH_UNLOAD: begin
                clk_en_o  = 1'b1;
                scan_en_o = 1'b1;
            end
            PH_ACT: begin
                clk_en_o  = 1'b1;
                scan_en_o = act_se;
            end
            default: begin
                clk_en_o  = 1'b0;
                scan_en_o = 1'b0;
            end
        endcase
    end

    assign shifting     = clk_en_o & scan_en_o;
    assign pat_req_o    = shifting;
    assign chain_si_o   = shifting & pat_i;
    assign resp_valid_o = (phase_i == PH_UNLOAD);
    assign resp_o       = resp_valid_o & chain_so_i;
    assign done_o       = (phase_i == PH_DONE);

    // R10
    se_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> clk_en_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!clk_en_o && !scan_en_o && !resp_valid_o));

    // R7
    done_follows_unload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(resp_valid_o));

endmodule

// File: rtl/mcyc_scan_seq.sv
module mcyc_scan_seq
    import mcyc_scan_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int MW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [MW-1:0] m_i,
    input  logic          pat_i,
    output logic          chain_si_o,
    input  logic          chain_so_i,
    output logic          pat_req_o,
    output logic          resp_o,
    output logic          resp_valid_o,
    output logic          scan_en_o,
    output logic          clk_en_o,
    output logic          done_o
);

    localparam int SHW = $clog2(CHAIN_LEN);
    localparam logic [SHW-1:0] SH_LIM = SHW'(CHAIN_LEN - 1);

    phase_e        phase;
    launch_e       mode;
    logic [MW-1:0] act_lim;
    logic [MW-1:0] act_cnt;
    logic [SHW-1:0] sh_cnt;
    logic          sh_en, act_en, clr;
    logic          sh_last, act_last;

    mcyc_scan_ctrl #(.MW(MW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .m_i       (m_i),
        .sh_last_i (sh_last),
        .act_last_i(act_last),
        .phase_o   (phase),
        .mode_o    (mode),
        .act_lim_o (act_lim),
        .sh_en_o   (sh_en),
        .act_en_o  (act_en),
        .clr_o     (clr)
    );

    mcyc_scan_count #(.W(SHW)) u_shift_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (sh_en),
        .limit_i(SH_LIM),
        .cnt_o  (sh_cnt),
        .last_o (sh_last)
    );

    mcyc_scan_count #(.W(MW)) u_act_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (act_en),
        .limit_i(act_lim),
        .cnt_o  (act_cnt),
        .last_o (act_last)
    );

    mcyc_scan_path #(.MW(MW)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .mode_i      (mode),
        .act_cnt_i   (act_cnt),
        .act_lim_i   (act_lim),
        .pat_i       (pat_i),
        .chain_so_i  (chain_so_i),
        .chain_si_o  (chain_si_o),
        .pat_req_o   (pat_req_o),
        .resp_o      (resp_o),
        .resp_valid_o(resp_valid_o),
        .scan_en_o   (scan_en_o),
        .clk_en_o    (clk_en_o),
        .done_o      (done_o)
    );

    // R10
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> $past(start_i));

    // R7
    shift_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && (sh_cnt != SH_LIM)) |=> resp_valid_o);

endmodule

// File: tb/sim_mcyc_scan_seq.sv
`timescale 1ns/1ps
module sim_mcyc_scan_seq;

    localparam int L  = 8;
    localparam int MW = 4;
    localparam logic [L-1:0] CUT_K = {(L/2){2'b10}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [MW-1:0] m_i = '0;
    logic          pat_i = 1'b0;
    logic          chain_si_o, chain_so_i, pat_req_o, resp_o, resp_valid_o;
    logic          scan_en_o, clk_en_o, done_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    mcyc_scan_seq #(.CHAIN_LEN(L), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .m_i(m_i),
        .pat_i(pat_i), .chain_si_o(chain_si_o), .chain_so_i(chain_so_i),
        .pat_req_o(pat_req_o), .resp_o(resp_o), .resp_valid_o(resp_valid_o),
        .scan_en_o(scan_en_o), .clk_en_o(clk_en_o), .done_o(done_o)
    );

    function automatic logic pgen(int k);
        logic [31:0] v;
        v = 32'(k) * 32'd40503 + 32'd12345;
        return ^v[17:9];
    endfunction

    function automatic logic [L-1:0] cut_f(logic [L-1:0] x);
        return {x[L-2:0], x[L-1]} ^ (x >> 2) ^ CUT_K;
    endfunction

    // chain and logic under test
    logic [L-1:0] ch = '0;
    logic [127:0] tr = '0;
    int           tn = 0;
    int           pcount = 0;

    assign chain_so_i = ch[L-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            ch <= '0;
        end else if (clk_en_o) begin
            if (scan_en_o) ch <= {ch[L-2:0], chain_si_o};
            else           ch <= cut_f(ch);
            tr <= {tr[126:0], scan_en_o};
            tn <= tn + 1;
        end
        if (pat_req_o) pcount <= pcount + 1;
    end

    always @(negedge clk) pat_i = pgen(pcount);

    // software expectation
    logic [L-1:0] sw_ch = '0;
    bit           sw_full = 1'b0;
    int           sw_pc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        sw_full = 1'b0;
        sw_ch = '0;
        @(negedge clk);
        chk(!scan_en_o && !clk_en_o && !done_o && !resp_valid_o && !pat_req_o, "R1",
            "idle outputs after reset",
            {scan_en_o, clk_en_o, done_o, resp_valid_o, pat_req_o}, 0);
    endtask

    task automatic run_one(input int md, input int mv, input bit inj);
        int me, mm, en, lat_exp, k, tn0;
        logic [L-1:0] x, eresp, rv;
        logic [127:0] etr, mask;
        string rtag;
        bit had_load;
        me = (mv == 0) ? 1 : mv;
        mm = (md == 3) ? 0 : md;
        rtag = (mm == 0) ? ((md == 3) ? "R3(code3)" : "R3") : (mm == 1) ? "R4" : "R5";
        if (mv == 0) rtag = {rtag, "/R6"};
        // expectation
        x = sw_ch; etr = '0; en = 0; had_load = !sw_full;
        if (had_load) begin
            for (int i = 0; i < L; i++) begin
                x = {x[L-2:0], pgen(sw_pc)}; sw_pc++;
                etr = {etr[126:0], 1'b1}; en++;
            end
        end
        for (int a = 0; a < me; a++) begin
            bit se;
            if (mm == 1)      se = (a == 0);
            else if (mm == 2) se = (a != me - 1);
            else              se = 1'b0;
            if (se) begin x = {x[L-2:0], pgen(sw_pc)}; sw_pc++; end
            else    x = cut_f(x);
            etr = {etr[126:0], se}; en++;
        end
        eresp = x;
        for (int i = 0; i < L; i++) begin
            x = {x[L-2:0], pgen(sw_pc)}; sw_pc++;
            etr = {etr[126:0], 1'b1}; en++;
        end
        sw_full = 1'b1;
        sw_ch = x;
        lat_exp = (had_load ? L : 0) + me + L + 1;
        mask = (128'd1 << en) - 128'd1;
        // stimulus
        @(negedge clk);
        tn0 = tn;
        mode_i = md[1:0]; m_i = mv[MW-1:0]; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1; rv = '0;
        while (1) begin
            if (resp_valid_o) rv = {rv[L-2:0], resp_o};
            if (done_o) break;
            if (inj && k == 3) begin
                start_i = 1'b1; mode_i = 2'((md + 1) % 4); m_i = MW'((mv + 5) % 16);
            end
            if (inj && k == 4) start_i = 1'b0;
            if (k > 300) begin
                chk(0, "R8", "done never seen", k, lat_exp);
                return;
            end
            @(negedge clk);
            k++;
        end
        chk(k == lat_exp, "R8", "done latency", k, lat_exp);
        if (inj) start_i = 1'b1;   // start in the done cycle (R9)
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!clk_en_o && !scan_en_o && !done_o && !resp_valid_o, inj ? "R9" : "R1",
                "idle after done", {clk_en_o, scan_en_o, done_o, resp_valid_o}, 0);
            @(negedge clk);
        end
        chk(((tr & mask) == etr) && (tn - tn0 == en), inj ? {rtag, "/R9"} : rtag,
            "scan-enable trace", tr & mask, etr);
        chk(rv == eresp, had_load ? "R2/R7" : "R7", "response", rv, eresp);
        chk(ch == sw_ch, "R7", "next vector in chain", ch, sw_ch);
        if (ch != sw_ch) sw_ch = ch;
    endtask

    initial begin
        #(200000 * 20);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        for (int md = 0; md < 4; md++) begin
            for (int mv = 0; mv < 16; mv++) begin
                run_one(md, mv, (mv % 5) == 2);
            end
        end
        // R2: load phase reappears after a fresh reset
        do_reset();
        run_one(1, 3, 1'b0);
        run_one(2, 1, 1'b1);
        finish_up();
    end

endmodule